// File: doc/BRIEF.md
# Radix-4 Multiple-Select Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns the exact 2N-bit product. It does not build one AND-row for each bit of the second operand. It first forms three multiples of the first operand: the operand itself, the operand doubled, and the operand tripled. The second operand is then read as base-4 digits. Each digit picks one of four values: zero or one of the three multiples. This halves the number of partial products. The partial products are shifted into place and summed by a balanced tree of adders, so the depth of the sum grows with the logarithm of the digit count.

The datapath is pipelined in three register stages: operand capture, partial-product selection and the summed result. A valid flag travels with the data through every stage. A new operand pair can be accepted on every clock. Each stage loads new data only when its valid flag is set, so an idle pipeline keeps its last result on the output.

Top module: `rmul_top`

## Requirements
- R1: The tripled multiple is formed as the operand plus the operand shifted left by one bit. It is held at N+2 bits, so the product is exact even when the first operand is all ones and a digit is 3 (for example 0xFF times 0x03 gives 0x02FD for N=8).
- R2: Digit i of the second operand occupies bits 2i+1 down to 2i. Digit values 0, 1, 2 and 3 select zero, the operand, the doubled operand and the tripled operand respectively.
- R3: The partial product of digit i is shifted left by 2i bits before summation, so a second operand holding a single nonzero digit d at position i yields the first operand times d times 4 to the power i.
- R4: For every pair of unsigned N-bit operands, `product` equals the full 2N-bit arithmetic product.
- R5: `out_valid` is high exactly three rising edges after the edge that samples `in_valid` high. It stays low for every cycle whose input three edges earlier was not valid.
- R6: A synchronous active-high reset clears `out_valid` and `product` to zero on the next rising edge.
- R7: Operand pairs offered on consecutive cycles produce results on consecutive cycles, in order, with no bubbles.
- R8: While `out_valid` is low, `product` keeps the last result it presented, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on op_a/op_b is to be multiplied |
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned, read as base-4 digits |
| out_valid | output | 1 | product holds a new result this cycle |
| product | output | 2N | Unsigned product of op_a and op_b |

## Verification
The bench builds two copies of the block. One copy uses N=8, which makes it feasible to stream all 65,536 operand pairs back to back, so every digit combination and every carry pattern in the adder tree is reached with no gaps in the pipeline. The other copy uses N=16, with eight digits and a three-level tree. It is driven with the all-ones and zero corners and with a few thousand random pairs. The single-digit operands, the idle gaps and the mid-stream reset are all run on the 8-bit copy, where the expected shifted multiples are easy to read.

// File: rtl/rmul_pkg.sv
package rmul_pkg;

    // Meaning of one base-4 digit of the multiplier operand (R2).
    typedef enum logic [1:0] {
        SEL_ZERO  = 2'd0,
        SEL_ONCE  = 2'd1,
        SEL_TWICE = 2'd2,
        SEL_THRICE = 2'd3
    } mul_sel_e;

    // Number of base-4 digits in an operand of the given width.
    function automatic int digit_count(input int width);
        return width / 2;
    endfunction

endpackage

// File: rtl/rmul_multiples.sv
// Forms the 1x, 2x and 3x copies of the multiplicand at N+2 bits (R1).
module rmul_multiples #(
    parameter int N = 8
) (
    input  logic [N-1:0] opnd,
    output logic [N+1:0] mul_one,
    output logic [N+1:0] mul_two,
    output logic [N+1:0] mul_three
);
    localparam int MW = N + 2;

    always_comb begin
        mul_one   = MW'(opnd);
        mul_two   = MW'(opnd) << 1;
        mul_three = mul_one + mul_two;
    end

endmodule

// File: rtl/rmul_digit_sel.sv
// Picks zero or one precomputed multiple for a single base-4 digit (R2).
module rmul_digit_sel
    import rmul_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] mul_one,
    input  logic [W-1:0] mul_two,
    input  logic [W-1:0] mul_three,
    input  mul_sel_e     sel,
    output logic [W-1:0] part
);
    always_comb begin
        unique case (sel)
            SEL_ONCE:   part = mul_one;
            SEL_TWICE:  part = mul_two;
            SEL_THRICE: part = mul_three;
            default:    part = '0;
        endcase
    end

endmodule

// File: rtl/rmul_add_tree.sv
// Balanced pairwise adder tree; leaves beyond NL are padded with zero.
module rmul_add_tree #(
    parameter int NL = 4,
    parameter int W  = 16
) (
    input  logic [NL-1:0][W-1:0] leaves,
    output logic [W-1:0]         total
);
    localparam int LV = (NL > 1) ? $clog2(NL) : 0;
    localparam int P  = 1 << LV;

    for (genvar l = 0; l <= LV; l++) begin : g_lv
        logic [(P >> l)-1:0][W-1:0] s;
        if (l == 0) begin : g_leaf
            for (genvar k = 0; k < P; k++) begin : g_k
                if (k < NL) begin : g_real
                    assign s[k] = leaves[k];
                end else begin : g_pad
                    assign s[k] = '0;
                end
            end
        end else begin : g_sum
            for (genvar k = 0; k < (P >> l); k++) begin : g_k
                assign s[k] = g_lv[l-1].s[2*k] + g_lv[l-1].s[2*k+1];
            end
        end
    end

    assign total = g_lv[LV].s[0];

endmodule

// File: rtl/rmul_top.sv
// Three-stage radix-4 multiple-select unsigned multiplier.
module rmul_top
    import rmul_pkg::*;
#(
    parameter int N = 8   // operand width, must be even and at least 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic           out_valid,
    output logic [2*N-1:0] product
);
    localparam int NG = digit_count(N);  // partial products
    localparam int PW = N + 2;           // width of one unshifted multiple
    localparam int RW = 2 * N;           // result width

    typedef struct packed {
        logic                  s1_v;
        logic [N-1:0]          s1_a;
        logic [N-1:0]          s1_b;
        logic                  s2_v;
        logic [NG-1:0][PW-1:0] s2_pp;
        logic                  s3_v;
        logic [RW-1:0]         s3_p;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [PW-1:0]         m1_w, m2_w, m3_w;
    logic [NG-1:0][PW-1:0] pp_w;
    logic [NG-1:0][RW-1:0] leaf_w;
    logic [RW-1:0]         sum_w;

    rmul_multiples #(.N(N)) u_mult (
        .opnd      (st_q.s1_a),
        .mul_one   (m1_w),
        .mul_two   (m2_w),
        .mul_three (m3_w)
    );

    for (genvar g = 0; g < NG; g++) begin : g_dig
        rmul_digit_sel #(.W(PW)) u_sel (
            .mul_one   (m1_w),
            .mul_two   (m2_w),
            .mul_three (m3_w),
            .sel       (mul_sel_e'(st_q.s1_b[2*g+1:2*g])),
            .part      (pp_w[g])
        );
        // Alignment of digit g by 2g bits (R3).
        assign leaf_w[g] = RW'(st_q.s2_pp[g]) << (2 * g);
    end

    rmul_add_tree #(.NL(NG), .W(RW)) u_tree (
        .leaves (leaf_w),
        .total  (sum_w)
    );

    always_comb begin
        st_d = st_q;
        st_d.s1_v = in_valid;
        if (in_valid) begin
            st_d.s1_a = op_a;
            st_d.s1_b = op_b;
        end
        st_d.s2_v = st_q.s1_v;
        if (st_q.s1_v) begin
            st_d.s2_pp = pp_w;
        end
        st_d.s3_v = st_q.s2_v;
        if (st_q.s2_v) begin
            st_d.s3_p = sum_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.s3_v;
    assign product   = st_q.s3_p;

endmodule

// File: rtl/rmul_chk.sv
// Port-level checker for rmul_top.
module rmul_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic           out_valid,
    input logic [2*N-1:0] product
);
    localparam int RW = 2 * N;

    logic [2:0] cyc;   // edges since reset, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= '0;
        end else if (cyc != 3'd7) begin
            cyc <= cyc + 3'd1;
        end
    end

    logic [RW-1:0] wide_a, wide_b;
    assign wide_a = RW'(op_a);
    assign wide_b = RW'(op_b);

    p_exact_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd3 && out_valid) |-> product == RW'($past(wide_a, 3) * $past(wide_b, 3)));

    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd3) |-> out_valid == $past(in_valid, 3));

    p_warmup_r5: assert property (@(posedge clk) disable iff (rst)
        (cyc < 3'd3) |-> !out_valid);

    p_clear_r6: assert property (@(posedge clk)
        rst |=> (!out_valid && product == '0));

    p_stream_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd4 && $past(in_valid, 3) && $past(in_valid, 4)) |-> (out_valid && $past(out_valid)));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd1 && !out_valid) |-> $stable(product));

endmodule

bind rmul_top rmul_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/rmul_top_tb.sv
module rmul_top_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;   // 100 MHz

    int checks = 0;
    int errors = 0;

    // 8-bit copy
    logic        v8 = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic        ov8;
    logic [15:0] p8;
    // 16-bit copy
    logic        v16 = 1'b0;
    logic [15:0] a16 = '0, b16 = '0;
    logic        ov16;
    logic [31:0] p16;

    rmul_top #(.N(8)) u_dut (
        .clk(clk), .rst(rst), .in_valid(v8), .op_a(a8), .op_b(b8),
        .out_valid(ov8), .product(p8)
    );

    rmul_top #(.N(16)) u_dut16 (
        .clk(clk), .rst(rst), .in_valid(v16), .op_a(a16), .op_b(b16),
        .out_valid(ov16), .product(p16)
    );

    // Expected-value history: index 2 is the pair driven three steps ago.
    logic [2:0]  h8_v = '0;
    logic [15:0] h8_p [3];
    logic [15:0] last8 = '0;
    logic [2:0]  h16_v = '0;
    logic [31:0] h16_p [3];
    logic [31:0] last16 = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_hist();
        h8_v = '0;  last8 = '0;
        h16_v = '0; last16 = '0;
        for (int i = 0; i < 3; i++) begin
            h8_p[i] = '0;
            h16_p[i] = '0;
        end
    endtask

    task automatic step8(input logic v, input logic [7:0] a, input logic [7:0] b, input string tag);
        @(negedge clk);
        if (h8_v[2]) begin
            chk(ov8 === 1'b1, {tag, " R5 valid"}, 32'(ov8), 32'd1);
            chk(p8 === h8_p[2], {tag, " product"}, 32'(p8), 32'(h8_p[2]));
            last8 = h8_p[2];
        end else begin
            chk(ov8 === 1'b0, {tag, " R5 idle"}, 32'(ov8), 32'd0);
            chk(p8 === last8, {tag, " R8 hold"}, 32'(p8), 32'(last8));
        end
        h8_v = {h8_v[1:0], v};
        h8_p[2] = h8_p[1];
        h8_p[1] = h8_p[0];
        h8_p[0] = {8'h00, a} * {8'h00, b};
        v8 = v; a8 = a; b8 = b;
    endtask

    task automatic step16(input logic v, input logic [15:0] a, input logic [15:0] b, input string tag);
        @(negedge clk);
        if (h16_v[2]) begin
            chk(ov16 === 1'b1, {tag, " R5 valid16"}, 32'(ov16), 32'd1);
            chk(p16 === h16_p[2], {tag, " product16"}, p16, h16_p[2]);
            last16 = h16_p[2];
        end else begin
            chk(ov16 === 1'b0, {tag, " R5 idle16"}, 32'(ov16), 32'd0);
            chk(p16 === last16, {tag, " R8 hold16"}, p16, last16);
        end
        h16_v = {h16_v[1:0], v};
        h16_p[2] = h16_p[1];
        h16_p[1] = h16_p[0];
        h16_p[0] = {16'h0000, a} * {16'h0000, b};
        v16 = v; a16 = a; b16 = b;
    endtask

    task automatic flush8(input string tag);
        for (int i = 0; i < 4; i++) step8(1'b0, 8'h5A, 8'hA5, tag);
    endtask

    // R6: reset clears outputs, both at start-up and in mid-stream.
    task automatic t_reset(input bit mid);
        if (mid) begin
            step8(1'b1, 8'hC3, 8'h7E, "R6 pre");
            step8(1'b1, 8'hFF, 8'hFF, "R6 pre");
            step8(1'b1, 8'h11, 8'h22, "R6 pre");
            step8(1'b1, 8'h99, 8'h66, "R6 pre");
        end
        @(negedge clk);
        rst = 1'b1;
        v8 = 1'b0; v16 = 1'b0;
        @(negedge clk);
        chk(ov8 === 1'b0, "R6 out_valid", 32'(ov8), 32'd0);
        chk(p8 === 16'h0, "R6 product", 32'(p8), 32'd0);
        chk(ov16 === 1'b0, "R6 out_valid16", 32'(ov16), 32'd0);
        chk(p16 === 32'h0, "R6 product16", p16, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        clear_hist();
    endtask

    // R2/R3: single nonzero digit at each position; R1: widest 3x cases.
    task automatic t_digits();
        for (int i = 0; i < 4; i++) begin
            for (int d = 0; d < 4; d++) begin
                step8(1'b1, 8'hB7, 8'(d << (2 * i)), "R2 R3 digit");
            end
        end
        step8(1'b1, 8'hFF, 8'h03, "R1 three");
        step8(1'b1, 8'hFF, 8'hC0, "R1 three top");
        step8(1'b1, 8'hFF, 8'hFF, "R1 all ones");
        step8(1'b1, 8'h80, 8'hFF, "R1 msb");
        flush8("R3 flush");
    endtask

    // R5: isolated and grouped pulses; out_valid only three edges later.
    task automatic t_gaps();
        step8(1'b1, 8'h0D, 8'h0E, "R5 single");
        step8(1'b0, 8'h00, 8'h00, "R5 gap");
        step8(1'b0, 8'h00, 8'h00, "R5 gap");
        step8(1'b1, 8'h21, 8'h43, "R5 pair");
        step8(1'b1, 8'h65, 8'h87, "R5 pair");
        step8(1'b0, 8'h00, 8'h00, "R5 gap");
        step8(1'b1, 8'hA9, 8'hCB, "R5 single");
        flush8("R5 flush");
    endtask

    // R8: operands change while in_valid is low; product must not move.
    task automatic t_hold();
        step8(1'b1, 8'h3C, 8'h5D, "R8 load");
        for (int i = 0; i < 8; i++) step8(1'b0, 8'(i * 37), 8'(255 - i * 11), "R8 idle");
        flush8("R8 flush");
    endtask

    // R4/R7: every operand pair, one per cycle.
    task automatic t_exhaustive();
        for (int i = 0; i < 65536; i++) begin
            step8(1'b1, 8'(i >> 8), 8'(i), "R4 R7 sweep");
        end
        flush8("R7 flush");
    endtask

    // R4 at N=16: corners and random pairs.
    task automatic t_wide();
        step16(1'b1, 16'hFFFF, 16'hFFFF, "R4 wide max");
        step16(1'b1, 16'h0000, 16'hBEEF, "R4 wide zero");
        step16(1'b1, 16'hFFFF, 16'h0001, "R4 wide one");
        step16(1'b1, 16'hFFFF, 16'hC000, "R1 wide three top");
        for (int i = 0; i < 3000; i++) begin
            step16(1'b1, 16'($urandom), 16'($urandom), "R4 wide rand");
        end
        for (int i = 0; i < 4; i++) step16(1'b0, 16'h1234, 16'h4321, "R8 wide flush");
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            checks++;
            $display("FAIL R5 watchdog actual=%0d expected<150000", wd);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_hist();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ov8 === 1'b0, "R6 start valid", 32'(ov8), 32'd0);
        chk(p8 === 16'h0, "R6 start product", 32'(p8), 32'd0);
        rst = 1'b0;
        t_digits();
        t_gaps();
        t_hold();
        t_reset(1'b1);
        t_exhaustive();
        t_wide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule